// File: doc/BRIEF.md
# Write-Back Data Rate Pattern Sequencer

This block paces the data words of a multi-word write-back on the system bus. When a burst starts, it captures a 4-bit rate code and a word count. The rate code picks a repeating frame of data cycles and idle cycles. After that, on every bus cycle the block says whether a data word is driven or the bus stays idle. It tells the data source when to move on to its next word, and it raises a one-cycle completion flag after the final word.

Each frame opens with one or two data cycles and then holds a fixed number of idle cycles. This lets a slow or narrow memory system take write-back data at the rate it can accept. Codes above the last defined pattern are reserved. Such a code falls back to full rate and latches an error indication that stays set until reset.

Top module: `wbr_seq_top`

## Requirements
- R1: After reset, `data_valid`, `word_adv`, `burst_done` and `rate_err` are all low.
- R2: With code 0, every cycle of the burst drives a data word, so N words take N consecutive cycles.
- R3: Codes 1, 2, 4, 5 and 7 repeat a frame of two data cycles followed by 1, 2, 3, 4 and 6 idle cycles respectively.
- R4: Codes 3, 6 and 8 repeat a frame of one data cycle followed by 1, 2 and 3 idle cycles respectively.
- R5: A burst asserts `data_valid` for exactly `word_count` cycles, and `data_valid` stays low after the last word until the next start.
- R6: `burst_done` is high for exactly one cycle, the cycle right after the last data cycle, and `data_valid` is low in that cycle.
- R7: `word_adv` is high in every data cycle except the final word of the burst, and never in an idle cycle.
- R8: A `start` pulse, even in the middle of a burst, reloads the count and code, and the next cycle is the first data cycle of the new frame.
- R9: A reserved code (9 to 15) paces the burst like code 0 and sets `rate_err`. `rate_err` then stays high until reset, whatever codes follow.
- R10: A start with `word_count` of 0 drives no data and pulses `burst_done` in the next cycle.
- R11: `data_valid` rises in the cycle after the clock edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_code | input | 4 | Rate code, sampled on `start` |
| start | input | 1 | One-cycle pulse that begins a burst |
| word_count | input | CNT_W | Number of words in the burst, sampled on `start` |
| data_valid | output | 1 | A data word is driven in this cycle |
| word_adv | output | 1 | The source should present its next word after this cycle |
| burst_done | output | 1 | One-cycle pulse after the final word |
| rate_err | output | 1 | Sticky flag: a reserved rate code was seen |

## Verification
Every defined code runs with a five-word burst. Five words end in different frame positions for one-slot and two-slot codes, so the bench can tell gap length, slot count and the point where the burst stops from one another. Single-word and zero-word bursts cover the end cases of the counter. A second start placed inside a gap, and another one partway through a frame, show that the pattern restarts at its first data cycle and does not resume from where it was. A burst with a reserved code, followed by a legal burst and then a reset, separates the full-rate fallback from the stickiness of the error flag.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  localparam int CODE_W   = 4;
  localparam int PH_W     = 3;
  localparam int LAST_DEF = 8;

  typedef struct packed {
    logic            two_slot;
    logic [PH_W-1:0] last_ph;
  } wbr_pat_t;

  function automatic wbr_pat_t wbr_decode(input logic [CODE_W-1:0] c);
    wbr_pat_t p;
    p.two_slot = 1'b0;
    p.last_ph  = '0;
    case (c)
      4'd1: begin p.two_slot = 1'b1; p.last_ph = 3'd2; end
      4'd2: begin p.two_slot = 1'b1; p.last_ph = 3'd3; end
      4'd3: begin p.two_slot = 1'b0; p.last_ph = 3'd1; end
      4'd4: begin p.two_slot = 1'b1; p.last_ph = 3'd4; end
      4'd5: begin p.two_slot = 1'b1; p.last_ph = 3'd5; end
      4'd6: begin p.two_slot = 1'b0; p.last_ph = 3'd2; end
      4'd7: begin p.two_slot = 1'b1; p.last_ph = 3'd7; end
      4'd8: begin p.two_slot = 1'b0; p.last_ph = 3'd3; end
      default: ;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/wbr_rst_sync.sv
module wbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/wbr_code_map.sv
module wbr_code_map
  import wbr_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output wbr_pat_t          pat,
  output logic              reserved
);
  always_comb begin
    pat      = wbr_decode(code);
    reserved = (code > CODE_W'(LAST_DEF));
  end
endmodule

// File: rtl/wbr_phase_gen.sv
module wbr_phase_gen
  import wbr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restart,
  input  logic     run,
  input  wbr_pat_t pat_in,
  output logic     data_slot
);
  wbr_pat_t        pat_q, pat_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            pat_en, ph_en;

  always_comb begin
    pat_en = restart;
    pat_d  = pat_in;
    ph_en  = restart | run;
    if (restart)                 ph_d = '0;
    else if (ph_q == pat_q.last_ph) ph_d = '0;
    else                         ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
      ph_q  <= '0;
    end else begin
      if (pat_en) pat_q <= pat_d;
      if (ph_en)  ph_q  <= ph_d;
    end
  end

  assign data_slot = (ph_q == '0) | (pat_q.two_slot & (ph_q == PH_W'(1)));

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= pat_q.last_ph); // R3
endmodule

// File: rtl/wbr_word_ctr.sv
module wbr_word_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             rem_en;

  always_comb begin
    rem_en = load | dec;
    rem_d  = load ? load_val : rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign busy = (rem_q != '0);
  assign last = (rem_q == CNT_W'(1));

  AST_LAST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && last) |=> !busy); // R5
endmodule

// File: rtl/wbr_seq_top.sv
module wbr_seq_top
  import wbr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              start,
  input  logic [CNT_W-1:0]  word_count,
  output logic              data_valid,
  output logic              word_adv,
  output logic              burst_done,
  output logic              rate_err
);
  logic     rst_s_n;
  wbr_pat_t pat;
  logic     reserved, data_slot, busy, last, dec;
  logic     done_q, done_d, err_q, err_d, err_en;

  wbr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  wbr_code_map u_map (
    .code(rate_code), .pat(pat), .reserved(reserved)
  );

  wbr_phase_gen u_phase (
    .clk(clk), .rst_n(rst_s_n), .restart(start), .run(busy & ~start),
    .pat_in(pat), .data_slot(data_slot)
  );

  wbr_word_ctr #(.CNT_W(CNT_W)) u_words (
    .clk(clk), .rst_n(rst_s_n), .load(start), .load_val(word_count),
    .dec(dec), .busy(busy), .last(last)
  );

  always_comb begin
    data_valid = busy & data_slot;
    word_adv   = data_valid & ~last;
    dec        = data_valid & ~start;
    done_d     = start ? (word_count == '0) : (data_valid & last);
    err_en     = start & reserved;
    err_d      = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (err_en) err_q <= err_d;
    end
  end

  assign burst_done = done_q;
  assign rate_err   = err_q;

  AST_ADV_IN_DATA: assert property (@(posedge clk) disable iff (!rst_s_n)
    word_adv |-> data_valid); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    burst_done |-> !data_valid); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_s_n)
    rate_err |=> rate_err); // R9
  AST_RESTART_DATA: assert property (@(posedge clk) disable iff (!rst_s_n)
    (start && word_count != '0) |=> data_valid); // R8
  AST_ZERO_WORDS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (start && word_count == '0) |=> (burst_done && !data_valid)); // R10
endmodule

// File: tb/sim_wbr_seq_top.sv
module sim_wbr_seq_top;
  localparam int PERIOD = 10;
  localparam int CNT_W  = 8;

  typedef struct {
    logic  dv;
    logic  adv;
    logic  done;
    string tag;
    string dtag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [3:0]       rate_code;
  logic             start;
  logic [CNT_W-1:0] word_count;
  logic             data_valid, word_adv, burst_done, rate_err;

  int   n_run = 0;
  int   n_fail = 0;
  exp_t sb[$];

  always #(PERIOD/2) clk = ~clk;

  wbr_seq_top #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .start(start),
    .word_count(word_count), .data_valid(data_valid), .word_adv(word_adv),
    .burst_done(burst_done), .rate_err(rate_err)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void pattern(input int code, output int d, output int p);
    case (code)
      1: begin d = 2; p = 3; end
      2: begin d = 2; p = 4; end
      3: begin d = 1; p = 2; end
      4: begin d = 2; p = 5; end
      5: begin d = 2; p = 6; end
      6: begin d = 1; p = 3; end
      7: begin d = 2; p = 8; end
      8: begin d = 1; p = 4; end
      default: begin d = 1; p = 1; end
    endcase
  endfunction

  task automatic run_burst(input int code, input int n, input int maxlen, input string tag);
    exp_t list[$];
    exp_t e;
    int d, p, ph, rem;
    pattern(code, d, p);
    ph = 0;
    rem = n;
    while (rem > 0) begin
      e.dv = (ph < d); e.adv = e.dv && (rem > 1); e.done = 1'b0;
      e.tag = tag; e.dtag = "R6";
      list.push_back(e);
      if (e.dv) rem--;
      ph = (ph + 1) % p;
    end
    e.dv = 1'b0; e.adv = 1'b0; e.done = 1'b1; e.tag = "R5";
    e.dtag = (n == 0) ? "R10" : "R6";
    list.push_back(e);
    e.done = 1'b0; e.dtag = "R6";
    list.push_back(e);
    if (maxlen > 0 && list.size() > maxlen) list = list[0:maxlen-1];
    rate_code  = 4'(code);
    word_count = CNT_W'(n);
    start      = 1'b1;
    foreach (list[i]) sb.push_back(list[i]);
    for (int i = 0; i < list.size(); i++) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(data_valid, e.dv,   e.tag,  "data_valid");
        check(word_adv,   e.adv,  "R7",   "word_adv");
        check(burst_done, e.done, e.dtag, "burst_done");
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0; start = 1'b0; rate_code = '0; word_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(data_valid, 1'b0, "R1", "data_valid");
    check(word_adv,   1'b0, "R1", "word_adv");
    check(burst_done, 1'b0, "R1", "burst_done");
    check(rate_err,   1'b0, "R1", "rate_err");

    run_burst(0, 5, 0, "R2");
    run_burst(0, 1, 0, "R2");
    run_burst(1, 5, 0, "R3");
    run_burst(2, 5, 0, "R3");
    run_burst(4, 5, 0, "R3");
    run_burst(5, 5, 0, "R3");
    run_burst(7, 5, 0, "R3");
    run_burst(3, 5, 0, "R4");
    run_burst(6, 5, 0, "R4");
    run_burst(8, 5, 0, "R4");
    run_burst(8, 1, 0, "R5");
    // R11: first data one cycle after start, no done in between
    run_burst(6, 2, 0, "R11");
    // R8: restart inside a gap, then partway through a frame
    run_burst(7, 6, 4, "R8");
    run_burst(7, 3, 0, "R8");
    run_burst(5, 4, 2, "R8");
    run_burst(3, 3, 0, "R8");
    // R10: empty burst
    run_burst(2, 0, 0, "R10");
    check(rate_err, 1'b0, "R9", "rate_err before reserved");
    // R9: reserved code paces like code 0 and latches error
    run_burst(12, 4, 0, "R9");
    check(rate_err, 1'b1, "R9", "rate_err set");
    run_burst(3, 2, 0, "R4");
    check(rate_err, 1'b1, "R9", "rate_err sticky");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rate_err, 1'b0, "R1", "rate_err after reset");
    check(data_valid, 1'b0, "R1", "data_valid after reset");
    run_burst(15, 3, 0, "R9");
    check(rate_err, 1'b1, "R9", "rate_err code 15");

    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule